// File: doc/BRIEF.md
# Stereo Digital Volume Controller

This block scales a stereo stream of signed 24-bit audio samples by a separate digital gain for each channel. Gain is chosen by a 9-bit code per channel, in quarter-decibel steps from about -100 dB up to +12 dB. The gained sample is rounded and clipped to the 24-bit range. A new sample pair is presented with a one-cycle valid strobe, and the gained pair appears one clock later.

Software writes the codes through a small register port. A code write is only staged in a shadow register. It becomes the live target when a write carries the commit bit, and that commit moves both channels' staged codes at once.

The path from the old code to a new target is set per direction. It can be an immediate step, a step held until the signal changes sign (with a timeout), or a soft ramp of one code per sample. Each channel can be muted on its own. A muted channel glides down to the lowest code and then outputs exact zeros.

Top module: `stereo_vol_ctrl`

## Requirements
- R1: For every cycle with `smp_valid` high, `out_valid` is high in the next cycle and the outputs carry that sample pair after gain. In a cycle after one without `smp_valid`, `out_valid` is low and both outputs keep their previous value.
- R2: Address 1 (left) and address 2 (right) take a code in `wr_data[8:0]`, which is only staged. When `wr_data[9]` is 1 on a write to either address, both channels' staged codes, including the one written, become the targets. A staged write without bit 9 leaves the output gain unchanged.
- R3: After reset both codes are 400 (0 dB), the control register is zero, `out_valid` is low and both outputs are zero.
- R4: For code c (codes above 448 act as 448), the gain is approximately 10^((c-400)/80). Codes 448-24n give exactly 4/2^n, so code 424 gives x2, code 400 gives x1 and code 376 gives x0.5. The product is rounded half toward positive infinity and then saturated to the range [-8388608, 8388607].
- R5: With control bits 0..2 clear, a committed code applies in full to the first sample after the commit.
- R6: Control bit 1 enables ramping for rising codes and bit 0 for falling codes. While a ramp is enabled for the direction of change, the code moves by one on each sample strobe, and that sample already uses the moved code. A direction without its ramp bit falls back to step or zero-cross behaviour.
- R7: With control bit 2 set and no ramp for that direction, a pending change applies to the first sample whose sign bit differs from the previous sample's sign bit (the previous sign is positive after reset). If no such sample arrives, the change applies to the 16th sample after the commit.
- R8: Control bit 3 mutes left and bit 4 mutes right. A muted channel's code falls by one per sample whatever the ramp bits say, and once it is 0 that channel outputs exactly 0. The other channel is unaffected. When mute is cleared, the code returns to its target under the mode rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register address: 0 control, 1 left code, 2 right code |
| wr_data | input | 10 | Write data |
| smp_valid | input | 1 | Sample pair strobe |
| smp_in_l | input | 24 | Left input sample, signed |
| smp_in_r | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Gained pair valid |
| smp_out_l | output | 24 | Left output sample, signed |
| smp_out_r | output | 24 | Right output sample, signed |

## Verification
Every gained pair is due exactly one clock after its strobe. The bench drives a strobe on a falling edge and reads the outputs on the next falling edge, half a cycle after the register has loaded. Register writes take effect on the next rising edge, so the first sample sent afterwards already sees the new target. Ramp, zero-cross timeout and mute results are counted in samples rather than cycles, so the checks land on the exact sample index at which R6, R7 and R8 say the code arrives.

// File: rtl/svc_pkg.sv
package svc_pkg;

    localparam int CODE_W        = 9;
    localparam int CODE_UNITY    = 400;
    localparam int CODE_TOP      = 448;
    localparam int STEPS_PER_OCT = 24;
    localparam int FRAC_W        = 16;
    localparam int FRAC_SHIFT    = 15;
    localparam int TOP_SHIFT     = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic mute_r;
        logic mute_l;
        logic zc_en;
        logic ramp_up_en;
        logic ramp_dn_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_VOL_L = 2'd1,
        ADDR_VOL_R = 2'd2
    } addr_e;

    // Q1.15 attenuation for k quarter-dB steps within one 6 dB octave.
    function automatic logic [FRAC_W-1:0] frac_of(input logic [4:0] k);
        case (k)
            5'd0:    frac_of = 16'd32768;
            5'd1:    frac_of = 16'd31838;
            5'd2:    frac_of = 16'd30935;
            5'd3:    frac_of = 16'd30057;
            5'd4:    frac_of = 16'd29205;
            5'd5:    frac_of = 16'd28376;
            5'd6:    frac_of = 16'd27571;
            5'd7:    frac_of = 16'd26789;
            5'd8:    frac_of = 16'd26029;
            5'd9:    frac_of = 16'd25290;
            5'd10:   frac_of = 16'd24573;
            5'd11:   frac_of = 16'd23875;
            5'd12:   frac_of = 16'd23198;
            5'd13:   frac_of = 16'd22540;
            5'd14:   frac_of = 16'd21900;
            5'd15:   frac_of = 16'd21279;
            5'd16:   frac_of = 16'd20675;
            5'd17:   frac_of = 16'd20089;
            5'd18:   frac_of = 16'd19519;
            5'd19:   frac_of = 16'd18965;
            5'd20:   frac_of = 16'd18427;
            5'd21:   frac_of = 16'd17904;
            5'd22:   frac_of = 16'd17396;
            default: frac_of = 16'd16903;
        endcase
    endfunction

endpackage

// File: rtl/svc_regs.sv
module svc_regs
    import svc_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [1:0]               wr_addr,
    input  logic [CODE_W:0]          wr_data,
    output ctrl_t                    ctrl,
    output logic [NCH-1:0][CODE_W-1:0] target
);

    logic commit;
    assign commit = wr_en && wr_data[CODE_W] &&
                    (wr_addr == ADDR_VOL_L || wr_addr == ADDR_VOL_R);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            ctrl <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [1:0] MY_ADDR = (g == 0) ? ADDR_VOL_L : ADDR_VOL_R;
        logic  hit;
        code_t shadow, shadow_nxt;

        assign hit        = wr_en && (wr_addr == MY_ADDR);
        assign shadow_nxt = hit ? wr_data[CODE_W-1:0] : shadow;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow    <= code_t'(CODE_UNITY);
                target[g] <= code_t'(CODE_UNITY);
            end else begin
                shadow <= shadow_nxt;
                if (commit) target[g] <= shadow_nxt;
            end
        end
    end

    AST_STAGE_HOLDS_TARGET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[CODE_W]) |=> $stable(target)); // R2

endmodule

// File: rtl/svc_code_ctrl.sv
module svc_code_ctrl
    import svc_pkg::*;
#(
    parameter int ZC_TIMEOUT = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  smp_valid,
    input  logic  smp_sign,
    input  code_t target,
    input  logic  mute,
    input  logic  ramp_up_en,
    input  logic  ramp_dn_en,
    input  logic  zc_en,
    output code_t code_now,
    output logic  silence
);

    localparam int CNT_W = $clog2(ZC_TIMEOUT) + 1;

    code_t             active, nxt, goal;
    logic [CNT_W-1:0]  wait_cnt, wait_nxt;
    logic              prev_sign;
    logic              crossed;

    assign goal    = mute ? '0 : target;
    assign crossed = smp_sign != prev_sign;

    always_comb begin
        nxt      = active;
        wait_nxt = '0;
        if (smp_valid && active != goal) begin
            if (mute) begin
                nxt = active - 1'b1;
            end else if (goal > active && ramp_up_en) begin
                nxt = active + 1'b1;
            end else if (goal < active && ramp_dn_en) begin
                nxt = active - 1'b1;
            end else if (zc_en) begin
                if (crossed || wait_cnt == CNT_W'(ZC_TIMEOUT - 1)) begin
                    nxt = goal;
                end else begin
                    wait_nxt = wait_cnt + 1'b1;
                end
            end else begin
                nxt = goal;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= code_t'(CODE_UNITY);
            wait_cnt  <= '0;
            prev_sign <= 1'b0;
        end else if (smp_valid) begin
            active    <= nxt;
            wait_cnt  <= wait_nxt;
            prev_sign <= smp_sign;
        end
    end

    assign code_now = nxt;
    assign silence  = mute && (nxt == '0);

    AST_CODE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(active)); // R6

    AST_MUTE_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mute && active != '0) |=> (active == $past(active) - 9'd1)); // R8

    AST_RAMP_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !mute && ramp_up_en && ramp_dn_en) |=>
        (active == $past(active) || active == $past(active) + 9'd1 ||
         active == $past(active) - 9'd1)); // R6

endmodule

// File: rtl/svc_gain.sv
module svc_gain
    import svc_pkg::*;
#(
    parameter int SW = 24
) (
    input  code_t          code,
    input  logic [SW-1:0]  sample,
    output logic [SW-1:0]  result
);

    localparam int PW = SW + FRAC_W + 2;
    localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (SW - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (SW - 1));

    code_t                 clamped, atten;
    logic [4:0]            octave, step;
    logic [FRAC_W-1:0]     frac;
    logic [5:0]            sh;
    logic signed [PW-1:0]  sx, fx, prod, rnd, sum, shifted;

    always_comb begin
        clamped = (code > code_t'(CODE_TOP)) ? code_t'(CODE_TOP) : code;
        atten   = code_t'(CODE_TOP) - clamped;
        octave  = 5'(atten / code_t'(STEPS_PER_OCT));
        step    = 5'(atten % code_t'(STEPS_PER_OCT));
        frac    = frac_of(step);
        sh      = 6'(FRAC_SHIFT - TOP_SHIFT) + 6'(octave);
        sx      = {{(PW-SW){sample[SW-1]}}, sample};
        fx      = {{(PW-FRAC_W){1'b0}}, frac};
        prod    = sx * fx;
        rnd     = PW'(1) <<< (sh - 6'd1);
        sum     = prod + rnd;
        shifted = sum >>> sh;
        if (shifted > MAXV)      result = MAXV[SW-1:0];
        else if (shifted < MINV) result = MINV[SW-1:0];
        else                     result = shifted[SW-1:0];
    end

endmodule

// File: rtl/stereo_vol_ctrl.sv
module stereo_vol_ctrl
    import svc_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int ZC_TIMEOUT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [CODE_W:0]     wr_data,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_in_l,
    input  logic [SAMPLE_W-1:0] smp_in_r,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] smp_out_l,
    output logic [SAMPLE_W-1:0] smp_out_r
);

    localparam int NCH = 2;

    ctrl_t                             ctrl;
    logic [NCH-1:0][CODE_W-1:0]        target;
    logic [NCH-1:0][SAMPLE_W-1:0]      smp_in, out_q;

    assign smp_in[0] = smp_in_l;
    assign smp_in[1] = smp_in_r;

    svc_regs #(.NCH(NCH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .target  (target)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        code_t                code_now;
        logic                 silence;
        logic [SAMPLE_W-1:0]  gained;

        svc_code_ctrl #(.ZC_TIMEOUT(ZC_TIMEOUT)) u_code (
            .clk        (clk),
            .rst        (rst),
            .smp_valid  (smp_valid),
            .smp_sign   (smp_in[g][SAMPLE_W-1]),
            .target     (target[g]),
            .mute       ((g == 0) ? ctrl.mute_l : ctrl.mute_r),
            .ramp_up_en (ctrl.ramp_up_en),
            .ramp_dn_en (ctrl.ramp_dn_en),
            .zc_en      (ctrl.zc_en),
            .code_now   (code_now),
            .silence    (silence)
        );

        svc_gain #(.SW(SAMPLE_W)) u_gain (
            .code   (code_now),
            .sample (smp_in[g]),
            .result (gained)
        );

        always_ff @(posedge clk) begin
            if (rst)            out_q[g] <= '0;
            else if (smp_valid) out_q[g] <= silence ? '0 : gained;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= smp_valid;
    end

    assign smp_out_l = out_q[0];
    assign smp_out_r = out_q[1];

    AST_OUT_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> out_valid); // R1

    AST_OUT_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> (!out_valid && $stable(smp_out_l) && $stable(smp_out_r))); // R1

endmodule

// File: tb/sim_stereo_vol_ctrl.sv
module sim_stereo_vol_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [9:0]  wr_data = '0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_in_l = '0, smp_in_r = '0;
    logic        out_valid;
    logic [23:0] smp_out_l, smp_out_r;

    int n_checks = 0, n_fail = 0;
    int got_l, got_r, got_v;
    bit done = 0;

    always #10 clk = ~clk;

    stereo_vol_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .smp_valid(smp_valid), .smp_in_l(smp_in_l), .smp_in_r(smp_in_r),
        .out_valid(out_valid), .smp_out_l(smp_out_l), .smp_out_r(smp_out_r)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        n_checks++;
        if (act <= lo || act >= hi) begin
            n_fail++;
            $display("FAIL %s actual %0d expected between %0d and %0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 10'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input int l, input int r);
        @(negedge clk);
        smp_valid = 1'b1; smp_in_l = 24'(l); smp_in_r = 24'(r);
        @(negedge clk);
        smp_valid = 1'b0;
        got_v = int'(out_valid);
        got_l = int'($signed(smp_out_l));
        got_r = int'($signed(smp_out_r));
    endtask

    task automatic t_reset();
        chk("R3 out_valid after reset", int'(out_valid), 0);
        chk("R3 left output after reset", int'($signed(smp_out_l)), 0);
        chk("R3 right output after reset", int'($signed(smp_out_r)), 0);
        send(1000, -1000);
        chk("R3 left unity code", got_l, 1000);
        chk("R3 right unity code", got_r, -1000);
    endtask

    task automatic t_latency();
        send(123, 456);
        chk("R1 out_valid one cycle after strobe", got_v, 1);
        chk("R1 left result", got_l, 123);
        @(negedge clk);
        chk("R1 out_valid low without strobe", int'(out_valid), 0);
        chk("R1 left output held", int'($signed(smp_out_l)), 123);
        chk("R1 right output held", int'($signed(smp_out_r)), 456);
    endtask

    task automatic t_gain();
        wr(1, 512 + 424);
        send(1000, 1000);
        chk("R4 code 424 doubles (R5 first sample)", got_l, 2000);
        chk("R4 right unchanged at unity", got_r, 1000);
        wr(1, 512 + 376);
        send(101, 0);
        chk("R4 code 376 halves, rounds up", got_l, 51);
        send(-101, 0);
        chk("R4 code 376 negative rounding", got_l, -50);
        wr(1, 512 + 448);
        send(3000000, 0);
        chk("R4 positive saturation", got_l, 8388607);
        send(-3000000, 0);
        chk("R4 negative saturation", got_l, -8388608);
        wr(1, 512 + 500);
        send(1000, 0);
        chk("R4 code above 448 clamps", got_l, 4000);
        wr(1, 512 + 400);
        send(1000, 0);
        chk("R5 step back to unity", got_l, 1000);
    endtask

    task automatic t_stage();
        wr(1, 424);
        send(1000, 1000);
        chk("R2 staged code has no effect", got_l, 1000);
        wr(2, 512 + 424);
        send(1000, 1000);
        chk("R2 commit applies staged left", got_l, 2000);
        chk("R2 commit applies written right", got_r, 2000);
        wr(1, 400);
        wr(2, 512 + 400);
        send(1000, 1000);
        chk("R2 both back to unity", got_l + got_r, 2000);
    endtask

    task automatic t_ramp();
        wr(0, 3);
        wr(1, 512 + 424);
        for (int i = 1; i <= 24; i++) begin
            send(1000, 1000);
            if (i == 1)  chk_range("R6 first ramp sample partial", got_l, 1000, 2000);
            if (i == 23) chk_range("R6 sample 23 still ramping", got_l, 1000, 2000);
        end
        chk("R6 ramp reaches target at sample 24", got_l, 2000);
        send(1000, 1000);
        chk("R6 ramp holds at target", got_l, 2000);
        wr(0, 1);
        wr(1, 512 + 448);
        send(1000, 1000);
        chk("R6 rising without ramp bit steps", got_l, 4000);
        wr(1, 512 + 400);
        send(1000, 1000);
        chk_range("R6 falling ramp first sample", got_l, 1000, 4000);
        for (int i = 2; i <= 48; i++) send(1000, 1000);
        chk("R6 falling ramp ends at sample 48", got_l, 1000);
    endtask

    task automatic t_zc();
        wr(0, 4);
        send(1000, 1000);
        wr(1, 512 + 424);
        send(1000, 1000);
        chk("R7 no sign change keeps old gain", got_l, 1000);
        send(-1000, 1000);
        chk("R7 sign change applies new gain", got_l, -2000);
        wr(1, 512 + 400);
        for (int i = 1; i <= 15; i++) send(-1000, 1000);
        chk("R7 sample 15 still waiting", got_l, -2000);
        send(-1000, 1000);
        chk("R7 timeout applies at sample 16", got_l, -1000);
    endtask

    task automatic t_mute();
        int right_bad = 0;
        wr(0, 8);
        for (int i = 1; i <= 400; i++) begin
            send(8000000, 8000000);
            if (got_r != 8000000) right_bad++;
            if (i == 399) chk_range("R8 code 1 still passes signal", got_l, 0, 8000000);
        end
        chk("R8 muted left is zero at code 0", got_l, 0);
        chk("R8 right unaffected by left mute", right_bad, 0);
        wr(0, 0);
        send(8000000, 8000000);
        chk("R8 unmute steps back to target", got_l, 8000000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_gain();
        t_stage();
        t_ramp();
        t_zc();
        t_mute();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule